// File: doc/BRIEF.md
# Serial Configuration Loader

This block loads a configuration image into a programmable-logic device whose configuration port is a slave-serial one. A single start pulse sets off the full sequence. The block switches on the target's power and waits for it to settle. It then holds the program line low for a fixed time and releases it. Next it waits, under a timeout, for the target to signal that it can take data. Once ready, it pulls the image bytes in through a valid/ready stream and shifts each one out, most significant bit first, on a data pin. A generated configuration clock carries the bits. When the last byte has gone out, the block keeps pulsing the clock until the target raises its done line, or until a pulse budget runs out.

The settling and program delays are counted in ticks of a divided clock, so one set of parameters gives millisecond delays at the system clock rate. An optional word-swap mode emits the bytes of each 4-byte word in reverse order. This mode is accepted only for an image whose start address is aligned to 4 bytes and whose length is a whole number of words. The result of each load is reported on an ok flag or an err flag. Either timeout raises err, which the surrounding chip can use to light its fault indicators.

Top module: `cfgl_loader`

## Requirements
- R1: After reset, busy, ok, err, pwr_en, cclk, din and in_ready are low and prog_n is high.
- R2: An accepted start (start high while busy is low) raises busy and pwr_en in the next cycle. pwr_en then stays high until reset. prog_n falls PWR_TICKS*TICK_DIV cycles after pwr_en is first driven by that start.
- R3: prog_n stays low for exactly PROG_TICKS*TICK_DIV cycles and then returns high. It is never low while pwr_en is low.
- R4: If init_in stays low, the block gives up after INIT_POLLS cycles. In that case err rises and busy falls exactly INIT_POLLS cycles after prog_n returns high, and no cclk pulse is produced.
- R5: Each bit is presented on din while cclk is low. cclk is then high for HALF cycles, and din does not change while cclk is high. Bits of a byte go out bit 7 first.
- R6: With swap low, the bytes appear on the serial pins in the order they were accepted on the stream.
- R7: With swap high, stream byte j is sent in position j XOR 3, giving the order 3,2,1,0,7,6,5,4 and so on.
- R8: A start with swap high and either base_lo not equal to 0 or img_len[1:0] not equal to 0 is rejected. err rises, busy stays low, prog_n stays high and pwr_en keeps its value.
- R9: After the last data bit, cclk is pulsed with din low until done_in is found high between pulses. ok then rises and busy falls. If done_in is already high, no extra pulse is produced.
- R10: If done_in never rises, exactly DONE_PULSES extra cclk pulses are produced, and then err rises and busy falls.
- R11: in_ready is high only while the block is fetching image bytes. Exactly img_len bytes are accepted per load, and none while idle.
- R12: A start pulse while busy is high is ignored: the running load keeps its length, order and result.
- R13: ok and err are never high together. Both are cleared in the cycle after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (ignored while busy) |
| swap | input | 1 | Reverse the byte order inside each 4-byte word |
| base_lo | input | 2 | Low two address bits of the image start |
| img_len | input | LEN_W | Image length in bytes |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a stream byte |
| init_in | input | 1 | Target ready-for-data line |
| done_in | input | 1 | Target configuration-complete line |
| pwr_en | output | 1 | Target power enable |
| prog_n | output | 1 | Active-low program line |
| cclk | output | 1 | Configuration clock |
| din | output | 1 | Configuration data |
| busy | output | 1 | Load in progress |
| ok | output | 1 | Last load completed |
| err | output | 1 | Last load timed out or was rejected |

## Verification
The assertions assume that init_in and done_in are synchronous to clk and that done_in, once raised, stays high until the next start. The bench drives both lines from its negative-edge process and holds them until the following load. The assertions also assume that in_valid holds a byte steady until it is taken. The bench changes in_data only after it has counted the handshake, and it inserts random idle cycles between bytes.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_PROG,
    ST_INIT,
    ST_STREAM,
    ST_FLUSH
  } cfgl_state_e;
endpackage

// File: rtl/cfgl_tick.sv
module cfgl_tick #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = $clog2(DIV + 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = en && (cnt_q == W'(DIV - 1));
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfgl_reorder.sv
module cfgl_reorder #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swap,
  input  logic          en,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);
  localparam int SLOTS = 4;

  logic [DW-1:0] slot_q [SLOTS];
  logic          drain_q, drain_d;
  logic [1:0]    k_q, k_d;
  logic [1:0]    last, flip;
  logic          wr;

  always_comb begin
    last      = swap ? 2'd3 : 2'd0;
    flip      = swap ? 2'd3 : 2'd0;
    in_ready  = en && !drain_q;
    out_valid = drain_q;
    out_data  = slot_q[k_q ^ flip];
    wr        = in_ready && in_valid;
    drain_d   = drain_q;
    k_d       = k_q;
    if (wr) begin
      if (k_q == last) begin drain_d = 1'b1; k_d = '0; end
      else             k_d = k_q + 2'd1;
    end else if (out_valid && out_ready) begin
      if (k_q == last) begin drain_d = 1'b0; k_d = '0; end
      else             k_d = k_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_q <= 1'b0;
      k_q     <= '0;
    end else begin
      drain_q <= drain_d;
      k_q     <= k_d;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr && (k_q == 2'(s))) slot_q[s] <= in_data;
    end
  end
endmodule

// File: rtl/cfgl_serial.sv
module cfgl_serial #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] data,
  input  logic       one_bit,
  output logic       busy,
  output logic       cclk,
  output logic       din
);
  localparam int HW = $clog2(HALF + 1);

  logic          busy_q, busy_d;
  logic          hi_q, hi_d;
  logic [7:0]    sh_q, sh_d;
  logic [2:0]    bit_q, bit_d;
  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    hi_d   = hi_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        hi_d   = 1'b0;
        sh_d   = data;
        bit_d  = one_bit ? 3'd0 : 3'd7;
        cnt_d  = '0;
      end
    end else if (cnt_q == HW'(HALF - 1)) begin
      cnt_d = '0;
      if (!hi_q) begin
        hi_d = 1'b1;
      end else begin
        hi_d = 1'b0;
        if (bit_q == 3'd0) begin
          busy_d = 1'b0;
          sh_d   = '0;
        end else begin
          sh_d  = {sh_q[6:0], 1'b0};
          bit_d = bit_q - 3'd1;
        end
      end
    end else begin
      cnt_d = cnt_q + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      hi_q   <= hi_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign cclk = hi_q;
  assign din  = sh_q[7];
endmodule

// File: rtl/cfgl_loader.sv
module cfgl_loader
  import cfgl_pkg::*;
#(
  parameter int TICK_DIV    = 50000,
  parameter int PWR_TICKS   = 50,
  parameter int PROG_TICKS  = 50,
  parameter int INIT_POLLS  = 100000,
  parameter int DONE_PULSES = 100000,
  parameter int HALF        = 2,
  parameter int LEN_W       = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             swap,
  input  logic [1:0]       base_lo,
  input  logic [LEN_W-1:0] img_len,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic             init_in,
  input  logic             done_in,
  output logic             pwr_en,
  output logic             prog_n,
  output logic             cclk,
  output logic             din,
  output logic             busy,
  output logic             ok,
  output logic             err
);
  localparam int M0   = (INIT_POLLS > DONE_PULSES) ? INIT_POLLS : DONE_PULSES;
  localparam int M1   = (PWR_TICKS > PROG_TICKS) ? PWR_TICKS : PROG_TICKS;
  localparam int MAXC = (M0 > M1) ? M0 : M1;
  localparam int CW   = $clog2(MAXC + 1);

  cfgl_state_e      st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [LEN_W-1:0] fetch_q, fetch_d, send_q, send_d;
  logic             swap_q, swap_d, pwr_q, pwr_d, ok_q, ok_d, err_q, err_d;

  logic       tick, tick_en, reject, go;
  logic       ro_en, ro_in_ready, ro_valid, ro_ready;
  logic [7:0] ro_data, ser_data;
  logic       ser_start, ser_one, ser_busy;

  cfgl_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(tick_en), .tick(tick)
  );

  cfgl_reorder #(.DW(8)) u_ro (
    .clk(clk), .rst_n(rst_n), .swap(swap_q), .en(ro_en),
    .in_valid(in_valid), .in_data(in_data), .in_ready(ro_in_ready),
    .out_valid(ro_valid), .out_data(ro_data), .out_ready(ro_ready)
  );

  cfgl_serial #(.HALF(HALF)) u_ser (
    .clk(clk), .rst_n(rst_n), .start(ser_start), .data(ser_data),
    .one_bit(ser_one), .busy(ser_busy), .cclk(cclk), .din(din)
  );

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    fetch_d   = fetch_q;
    send_d    = send_q;
    swap_d    = swap_q;
    pwr_d     = pwr_q;
    ok_d      = ok_q;
    err_d     = err_q;
    ser_start = 1'b0;
    ser_one   = 1'b0;
    ser_data  = ro_data;
    ro_ready  = 1'b0;
    tick_en   = (st_q == ST_PWR) || (st_q == ST_PROG);
    ro_en     = (st_q == ST_STREAM) && (fetch_q != '0);
    reject    = swap && ((base_lo != 2'd0) || (img_len[1:0] != 2'd0));
    go        = start && (st_q == ST_IDLE);

    unique case (st_q)
      ST_IDLE: begin
        if (go) begin
          ok_d = 1'b0;
          if (reject) begin
            err_d = 1'b1;
          end else begin
            err_d   = 1'b0;
            pwr_d   = 1'b1;
            st_d    = ST_PWR;
            cnt_d   = '0;
            swap_d  = swap;
            fetch_d = img_len;
            send_d  = img_len;
          end
        end
      end
      ST_PWR: begin
        if (tick) begin
          if (cnt_q == CW'(PWR_TICKS - 1)) begin st_d = ST_PROG; cnt_d = '0; end
          else cnt_d = cnt_q + CW'(1);
        end
      end
      ST_PROG: begin
        if (tick) begin
          if (cnt_q == CW'(PROG_TICKS - 1)) begin st_d = ST_INIT; cnt_d = '0; end
          else cnt_d = cnt_q + CW'(1);
        end
      end
      ST_INIT: begin
        if (init_in) begin
          st_d  = ST_STREAM;
          cnt_d = '0;
        end else if (cnt_q == CW'(INIT_POLLS - 1)) begin
          st_d  = ST_IDLE;
          err_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_STREAM: begin
        if (ro_in_ready && in_valid) fetch_d = fetch_q - LEN_W'(1);
        if (!ser_busy) begin
          if (send_q == '0) begin
            st_d  = ST_FLUSH;
            cnt_d = '0;
          end else if (ro_valid) begin
            ser_start = 1'b1;
            ro_ready  = 1'b1;
            send_d    = send_q - LEN_W'(1);
          end
        end
      end
      ST_FLUSH: begin
        ser_data = 8'h00;
        if (!ser_busy) begin
          if (done_in) begin
            st_d = ST_IDLE;
            ok_d = 1'b1;
          end else if (cnt_q == CW'(DONE_PULSES)) begin
            st_d  = ST_IDLE;
            err_d = 1'b1;
          end else begin
            ser_start = 1'b1;
            ser_one   = 1'b1;
            cnt_d     = cnt_q + CW'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      fetch_q <= '0;
      send_q  <= '0;
      swap_q  <= 1'b0;
      pwr_q   <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      fetch_q <= fetch_d;
      send_q  <= send_d;
      swap_q  <= swap_d;
      pwr_q   <= pwr_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
    end
  end

  assign in_ready = ro_in_ready;
  assign pwr_en   = pwr_q;
  assign prog_n   = (st_q != ST_PROG);
  assign busy     = (st_q != ST_IDLE);
  assign ok       = ok_q;
  assign err      = err_q;
endmodule

// File: rtl/cfgl_loader_chk.sv
module cfgl_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic done_in,
  input logic pwr_en,
  input logic prog_n,
  input logic cclk,
  input logic din,
  input logic busy,
  input logic ok,
  input logic err
);
  AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && err)); // R13

  AST_PROG_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> pwr_en); // R3

  AST_PWR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en |=> pwr_en); // R2

  AST_DIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk && $past(cclk)) |-> $stable(din)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cclk && prog_n && !in_ready)); // R11

  AST_OK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok) |-> ($past(done_in) && !busy)); // R9
endmodule

bind cfgl_loader cfgl_loader_chk u_chk (.*);

// File: tb/sim_cfgl_loader.sv
module sim_cfgl_loader;
  localparam int TICK_DIV = 4, PWR_TICKS = 3, PROG_TICKS = 5;
  localparam int INIT_POLLS = 40, DONE_PULSES = 30, HALF = 2, LEN_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, swap = 0, in_valid = 0, init_in = 0, done_in = 0;
  logic [1:0] base_lo = 0;
  logic [LEN_W-1:0] img_len = 0;
  logic [7:0] in_data = 0;
  logic in_ready, pwr_en, prog_n, cclk, din, busy, ok, err;

  cfgl_loader #(.TICK_DIV(TICK_DIV), .PWR_TICKS(PWR_TICKS), .PROG_TICKS(PROG_TICKS),
    .INIT_POLLS(INIT_POLLS), .DONE_PULSES(DONE_PULSES), .HALF(HALF), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .swap(swap), .base_lo(base_lo),
    .img_len(img_len), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .init_in(init_in), .done_in(done_in), .pwr_en(pwr_en), .prog_n(prog_n),
    .cclk(cclk), .din(din), .busy(busy), .ok(ok), .err(err));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] img [64];
  logic [7:0] got [64];
  int cur_len = 0, in_idx = 0, rises = 0, flush_rises = 0, flush_din = 0, glitch = 0;
  int over_req = 0, init_dly = -1, done_after = -1;
  int prog_fall_cyc = 0, prog_rise_cyc = 0;
  bit fire_pending = 0, cclk_prev = 0, din_prev = 0, prog_prev = 1, prog_rise_seen = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (cclk && !cclk_prev) begin
      if (rises < 8 * cur_len) got[rises / 8] = {got[rises / 8][6:0], din};
      else begin
        flush_rises++;
        if (din) flush_din++;
      end
      rises++;
    end
    if (cclk && cclk_prev && (din != din_prev)) glitch++;
    cclk_prev = cclk; din_prev = din;
    if (!prog_n && prog_prev) prog_fall_cyc = cyc;
    if (prog_n && !prog_prev) begin prog_rise_cyc = cyc; prog_rise_seen = 1; end
    prog_prev = prog_n;
    init_in = prog_rise_seen && (init_dly >= 0) && (cyc - prog_rise_cyc >= init_dly);
    done_in = (done_after >= 0) && (flush_rises >= done_after);
    if (fire_pending) in_idx++;
    if (in_ready && in_idx >= cur_len) over_req++;
    in_valid = (in_idx < cur_len) && ($urandom % 4 != 0);
    in_data  = img[in_idx % 64];
    fire_pending = in_valid && in_ready;
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int j, input bit sw);
    return sw ? img[j ^ 3] : img[j];
  endfunction

  // mode 0: success, 1: init never rises, 2: done never rises
  task automatic run(input int len, input bit sw, input int mode, input int idly,
                     input int dafter, input bit poke);
    int start_cyc, end_cyc, bad, first_bad;
    bit poked = 0;
    for (int i = 0; i < 64; i++) img[i] = 8'($urandom);
    cur_len = len; in_idx = 0; rises = 0; flush_rises = 0; flush_din = 0;
    glitch = 0; over_req = 0; prog_rise_seen = 0;
    init_dly = (mode == 1) ? -1 : idly;
    done_after = (mode == 2) ? -1 : dafter;
    @(negedge clk);
    start = 1; swap = sw; base_lo = 0; img_len = LEN_W'(len); start_cyc = cyc;
    @(negedge clk);
    start = 0;
    chk(busy && pwr_en, "R2 busy/pwr after start", int'(busy), 1);
    chk(!ok && !err, "R13 flags cleared on start", int'({ok, err}), 0);
    while (busy) begin
      @(negedge clk);
      if (poke && !poked && rises >= 4) begin
        start = 1; swap = ~sw; base_lo = 2'd1; img_len = 8'd3; poked = 1;
      end else start = 0;
    end
    start = 0;
    end_cyc = cyc;
    chk(prog_fall_cyc - start_cyc == PWR_TICKS * TICK_DIV + 1, "R2 power to program delay",
        prog_fall_cyc - start_cyc, PWR_TICKS * TICK_DIV + 1);
    chk(prog_rise_cyc - prog_fall_cyc == PROG_TICKS * TICK_DIV, "R3 program low width",
        prog_rise_cyc - prog_fall_cyc, PROG_TICKS * TICK_DIV);
    chk(glitch == 0, "R5 din change while cclk high", glitch, 0);
    chk(over_req == 0, "R11 in_ready beyond length", over_req, 0);
    if (mode == 1) begin
      chk(err && !ok, "R4 init timeout err", int'({ok, err}), 1);
      chk(end_cyc - prog_rise_cyc == INIT_POLLS, "R4 init timeout length",
          end_cyc - prog_rise_cyc, INIT_POLLS);
      chk(rises == 0, "R4 no clock on init timeout", rises, 0);
    end else begin
      bad = 0; first_bad = -1;
      for (int j = 0; j < len; j++)
        if (got[j] !== exp_byte(j, sw)) begin bad++; if (first_bad < 0) first_bad = j; end
      if (first_bad < 0) first_bad = 0;
      chk(bad == 0, sw ? "R7 swapped byte order" : "R6 stream byte order",
          int'(got[first_bad]), int'(exp_byte(first_bad, sw)));
      chk(in_idx == len, "R11 bytes accepted", in_idx, len);
      chk(flush_din == 0, "R9 din low during flush", flush_din, 0);
      if (mode == 0) begin
        chk(ok && !err, "R9 ok after done", int'({ok, err}), 2);
        chk(flush_rises == dafter, "R9 flush pulse count", flush_rises, dafter);
        if (poke) chk(poked && ok, "R12 start while busy ignored", int'(ok), 1);
      end else begin
        chk(err && !ok, "R10 done timeout err", int'({ok, err}), 1);
        chk(flush_rises == DONE_PULSES, "R10 flush pulse budget", flush_rises, DONE_PULSES);
      end
    end
    done_after = -1; init_dly = -1;
    @(negedge clk);
  endtask

  task automatic reject(input logic [1:0] base, input int len);
    bit pwr_before = pwr_en;
    int bad = 0;
    @(negedge clk);
    start = 1; swap = 1; base_lo = base; img_len = LEN_W'(len);
    @(negedge clk);
    start = 0;
    chk(err && !ok, "R8 reject raises err", int'({ok, err}), 1);
    for (int i = 0; i < 20; i++) begin
      if (busy || !prog_n || (pwr_en != pwr_before)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R8 rejected start leaves block idle", bad, 0);
  endtask

  initial begin
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk);
    chk(!busy && !ok && !err && !pwr_en && !cclk && !din && !in_ready && prog_n,
        "R1 reset outputs", int'({busy, ok, err, pwr_en, cclk, din, in_ready, prog_n}), 1);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && prog_n && !pwr_en, "R1 idle after reset", int'(busy), 0);
    reject(2'd2, 8);
    run(8, 0, 0, 5, 3, 0);
    run(12, 1, 0, 0, 1, 0);
    run(6, 0, 0, 3, 2, 1);
    run(4, 1, 1, 0, 0, 0);
    run(5, 0, 2, 2, 0, 0);
    run(0, 0, 0, 1, 4, 0);
    run(3, 0, 0, 2, 0, 0);
    reject(2'd0, 6);
    for (int r = 0; r < 6; r++) begin
      bit sw = 1'($urandom % 2);
      int len = sw ? 4 * (1 + $urandom % 4) : 1 + $urandom % 13;
      run(len, sw, 0, $urandom % 10, $urandom % 6, 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule